// File: doc/BRIEF.md
# Serial FPGA Configuration Master

This block loads a configuration bitstream into an FPGA whose configuration port is in slave-serial mode. A start pulse, together with a total byte count, begins a load. The block first raises its programming request and waits for the target device to report that its initialisation phase has begun. It then releases the request and waits for that initialisation indication to clear. After that it pulls bytes from a valid/ready stream and shifts each byte out on the serial data line, one bit for each configuration clock period.

Before each byte is sent, the block checks the device's status lines. An initialisation indication that reappears while the device's completion line is still low means the device found a checksum error, and the load stops. Once the last byte is sent, the block holds the data line high and keeps pulsing the configuration clock until the device raises its completion line. Every wait on the device is bounded by a timeout. When a load ends, exactly one of three result flags is raised: success, timeout or checksum error. The flag holds until the next start.

Configuration clock pacing is set by a half-period parameter, given in system clocks. The timeout length is the product of the system clock frequency in MHz and the wait time in microseconds. Both device status inputs pass through a two-flop synchronizer.

The state machine has eight states. IDLE waits for a start. REQ drives the programming request and waits for the initialisation indication. CLR waits for that indication to clear. NEXT checks for a checksum error and takes a byte. BLO and BHI are the low and high halves of one data bit. FLO and FHI are the low and high halves of a post-load clock pulse. The transitions are as follows.
- IDLE to REQ on a start.
- REQ to CLR when the indication is seen, or REQ to IDLE on timeout.
- CLR to NEXT when the indication clears, or CLR to IDLE on timeout.
- NEXT to BLO when a byte is taken.
- NEXT to IDLE on a checksum error.
- NEXT to FLO when no bytes remain.
- BLO to BHI at the end of the low half.
- BHI to BLO at the end of the high half while bits remain in the byte, or BHI to NEXT after the eighth bit.
- FLO to FHI at the end of the low half.
- FHI to FLO at the end of the high half when the completion line is still low.
- FHI to IDLE with success when a high half ends with the completion line high.
- FLO or FHI to IDLE on timeout.

Top module: `fpga_serial_loader`

## Requirements
- R1: After reset, and whenever `busy_o` is low, `prog_o`, `cclk_o`, `byte_ready_o` and all three result flags are 0, until the first start.
- R2: A `start_i` pulse while idle raises `busy_o` and `prog_o` in the next cycle and clears all result flags. `prog_o` drops in the cycle after the synchronized `init_i` is seen high. With `init_i` driven high in the first cycle of `prog_o`, that is exactly 3 cycles of `prog_o`.
- R3: No rising edge of `cclk_o` occurs while `prog_o` is high, or before `init_i` has returned low after the request.
- R4: Each device wait (for `init_i` to rise, for `init_i` to clear, and for `done_i` after the data) lasts at most TMO = CLK_MHZ*WAIT_US cycles. On expiry, `tmo_o` is set and `busy_o` drops. With `init_i` never rising, `busy_o` lasts exactly TMO cycles. With `init_i` rising but never clearing, it lasts 3+TMO cycles.
- R5: Exactly `len_i` bytes are taken from the stream in order. Each is sent most-significant bit first, eight bits per byte, and `din_o` is sampled by the device on the rising edge of `cclk_o`. The stream may stall between bytes.
- R6: Within a byte and during post-load clocking, every high and low half of `cclk_o` lasts HALF_CYC system clocks. `din_o` does not change while `cclk_o` is high.
- R7: If, before a byte is taken, the synchronized `init_i` is high while `done_i` is low, the load ends with `crc_o` set, and no further byte is taken.
- R8: After the last byte, `din_o` is 1 on every further `cclk_o` rising edge. Pulses continue until `done_i` is seen high at the end of a high half, and then `ok_o` is set.
- R9: If `done_i` never rises after the data, the post-load clocking ends by timeout with `tmo_o` set.
- R10: A `start_i` pulse while `busy_o` is high is ignored. The running load keeps its byte count and its result.
- R11: At most one result flag is high at any time. The flags keep their value while idle until the next start.
- R12: A start with `len_i` = 0 sends no data bits and goes straight to post-load clocking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, taken only while idle |
| len_i | input | CNT_W | Number of bytes in the load, sampled at start |
| byte_data_i | input | 8 | Stream byte |
| byte_valid_i | input | 1 | Stream byte valid |
| byte_ready_o | output | 1 | Block takes the byte this cycle if valid |
| prog_o | output | 1 | Programming request to the device (active high) |
| cclk_o | output | 1 | Configuration clock |
| din_o | output | 1 | Serial configuration data |
| init_i | input | 1 | Device initialisation / error indication (active high) |
| done_i | input | 1 | Device configuration complete |
| busy_o | output | 1 | Load in progress |
| ok_o | output | 1 | Last load completed |
| tmo_o | output | 1 | Last load ended by timeout |
| crc_o | output | 1 | Last load ended by a device checksum error |

## Verification
The bench plays the device, with a programming handshake that can be made to fail at either step. It compares every `cclk_o` rising edge against a queue of expected bits and measures each clock half. A design that shifted least-significant bit first, or dropped a bit at a byte boundary, would fail the bit-queue comparison. A timer that was off by one, or that did not restart between the two initialisation waits, would give the wrong busy length in the exact-length timeout cases. A checksum check placed after the byte is taken, rather than before, would take an extra byte. A start that was not ignored mid-load would change the byte count. The bench also covers a zero-length load and a device that never signals completion.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_CLR,
        ST_NEXT,
        ST_BLO,
        ST_BHI,
        ST_FLO,
        ST_FHI
    } cfg_state_e;

    localparam int BYTE_BITS = 8;

endpackage

// File: rtl/cfg_sync2.sv
module cfg_sync2 #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/cfg_wait_timer.sv
module cfg_wait_timer #(
    parameter int LIMIT = 1000,
    parameter int W     = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic expired
);
    logic [W-1:0] cnt_q;

    assign expired = run && (cnt_q == W'(LIMIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || restart) begin
            cnt_q <= '0;
        end else if (!expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/cfg_half_timer.sv
module cfg_half_timer #(
    parameter int HALF = 4,
    parameter int W    = (HALF > 1) ? $clog2(HALF) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic last
);
    logic [W-1:0] cnt_q;

    assign last = run && (cnt_q == W'(HALF - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || last) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/fpga_serial_loader.sv
module fpga_serial_loader
    import cfg_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int HALF_CYC = 4,
    parameter int CLK_MHZ  = 250,
    parameter int WAIT_US  = 10000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] len_i,
    input  logic [7:0]       byte_data_i,
    input  logic             byte_valid_i,
    output logic             byte_ready_o,
    output logic             prog_o,
    output logic             cclk_o,
    output logic             din_o,
    input  logic             init_i,
    input  logic             done_i,
    output logic             busy_o,
    output logic             ok_o,
    output logic             tmo_o,
    output logic             crc_o
);
    localparam int TMO   = CLK_MHZ * WAIT_US;
    localparam int BIT_W = $clog2(BYTE_BITS);

    cfg_state_e state_q, state_n;

    logic [1:0]       sync_q;
    logic             init_s, done_s;
    logic             tmr_run, tmr_restart, tmr_exp;
    logic             ph_run, ph_last;
    logic [CNT_W-1:0] rem_q;
    logic [7:0]       sh_q;
    logic [BIT_W-1:0] bit_q;
    logic             ok_q, tmo_q, crc_q;
    logic             fin_ok, fin_tmo, fin_crc;
    logic             crc_hit, take;

    cfg_sync2 #(.W(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({init_i, done_i}),
        .q     (sync_q)
    );
    assign init_s = sync_q[1];
    assign done_s = sync_q[0];

    assign tmr_run     = (state_q == ST_REQ) || (state_q == ST_CLR) ||
                         (state_q == ST_FLO) || (state_q == ST_FHI);
    assign tmr_restart = (state_q == ST_REQ) && init_s;

    cfg_wait_timer #(.LIMIT(TMO)) u_wait (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (tmr_run),
        .restart (tmr_restart),
        .expired (tmr_exp)
    );

    assign ph_run = (state_q == ST_BLO) || (state_q == ST_BHI) ||
                    (state_q == ST_FLO) || (state_q == ST_FHI);

    cfg_half_timer #(.HALF(HALF_CYC)) u_half (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (ph_run),
        .last  (ph_last)
    );

    assign crc_hit = init_s && !done_s;
    assign take    = byte_ready_o && byte_valid_i;

    // next-state and load-result decode
    always_comb begin
        state_n = state_q;
        fin_ok  = 1'b0;
        fin_tmo = 1'b0;
        fin_crc = 1'b0;
        unique case (state_q)
            ST_IDLE: if (start_i) state_n = ST_REQ;
            ST_REQ: begin
                if (init_s) begin
                    state_n = ST_CLR;
                end else if (tmr_exp) begin
                    state_n = ST_IDLE;
                    fin_tmo = 1'b1;
                end
            end
            ST_CLR: begin
                if (!init_s) begin
                    state_n = ST_NEXT;
                end else if (tmr_exp) begin
                    state_n = ST_IDLE;
                    fin_tmo = 1'b1;
                end
            end
            ST_NEXT: begin
                if (rem_q == '0) begin
                    state_n = ST_FLO;
                end else if (crc_hit) begin
                    state_n = ST_IDLE;
                    fin_crc = 1'b1;
                end else if (byte_valid_i) begin
                    state_n = ST_BLO;
                end
            end
            ST_BLO: if (ph_last) state_n = ST_BHI;
            ST_BHI: begin
                if (ph_last) begin
                    state_n = (bit_q == BIT_W'(BYTE_BITS - 1)) ? ST_NEXT : ST_BLO;
                end
            end
            ST_FLO: begin
                if (tmr_exp) begin
                    state_n = ST_IDLE;
                    fin_tmo = 1'b1;
                end else if (ph_last) begin
                    state_n = ST_FHI;
                end
            end
            ST_FHI: begin
                if (ph_last && done_s) begin
                    state_n = ST_IDLE;
                    fin_ok  = 1'b1;
                end else if (tmr_exp) begin
                    state_n = ST_IDLE;
                    fin_tmo = 1'b1;
                end else if (ph_last) begin
                    state_n = ST_FLO;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // datapath and result flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
            sh_q  <= '0;
            bit_q <= '0;
            ok_q  <= 1'b0;
            tmo_q <= 1'b0;
            crc_q <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && start_i) begin
                rem_q <= len_i;
                ok_q  <= 1'b0;
                tmo_q <= 1'b0;
                crc_q <= 1'b0;
            end
            if (take) begin
                sh_q  <= byte_data_i;
                bit_q <= '0;
            end
            if (state_q == ST_BHI && ph_last) begin
                if (bit_q == BIT_W'(BYTE_BITS - 1)) begin
                    rem_q <= rem_q - 1'b1;
                end else begin
                    sh_q  <= {sh_q[6:0], 1'b0};
                    bit_q <= bit_q + 1'b1;
                end
            end
            if (fin_ok)  ok_q  <= 1'b1;
            if (fin_tmo) tmo_q <= 1'b1;
            if (fin_crc) crc_q <= 1'b1;
        end
    end

    // outputs decoded from state
    always_comb begin
        prog_o       = 1'b0;
        cclk_o       = 1'b0;
        din_o        = 1'b0;
        byte_ready_o = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_REQ:  prog_o = 1'b1;
            ST_CLR:  ;
            ST_NEXT: byte_ready_o = (rem_q != '0) && !crc_hit;
            ST_BLO:  din_o = sh_q[7];
            ST_BHI: begin
                din_o  = sh_q[7];
                cclk_o = 1'b1;
            end
            ST_FLO:  din_o = 1'b1;
            ST_FHI: begin
                din_o  = 1'b1;
                cclk_o = 1'b1;
            end
            default: ;
        endcase
    end

    assign busy_o = (state_q != ST_IDLE);
    assign ok_o   = ok_q;
    assign tmo_o  = tmo_q;
    assign crc_o  = crc_q;

endmodule

// File: rtl/fpga_serial_loader_chk.sv
module fpga_serial_loader_chk #(
    parameter int TMO = 1000
) (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic byte_ready_o,
    input logic prog_o,
    input logic cclk_o,
    input logic din_o,
    input logic busy_o,
    input logic ok_o,
    input logic tmo_o,
    input logic crc_o
);
    int unsigned pcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                pcnt <= 0;
        else if (!prog_o)          pcnt <= 0;
        else if (pcnt < TMO + 2)   pcnt <= pcnt + 1;
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!prog_o && !cclk_o && !byte_ready_o));

    p_start_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (prog_o && !ok_o && !tmo_o && !crc_o));

    p_prog_no_clk_r3: assert property (@(posedge clk) disable iff (!rst_n)
        prog_o |-> !cclk_o);

    p_prog_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
        prog_o |-> (pcnt < TMO));

    p_ready_low_clk_r5: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ready_o |-> (!cclk_o && !prog_o));

    p_din_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cclk_o && $past(cclk_o)) |-> $stable(din_o));

    p_flags_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ok_o, tmo_o, crc_o}));

    p_flags_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !$past(busy_o) && !$past(start_i)) |-> $stable({ok_o, tmo_o, crc_o}));

endmodule

bind fpga_serial_loader fpga_serial_loader_chk #(.TMO(TMO)) u_chk (.*);

// File: tb/fpga_serial_loader_bench.sv
module fpga_serial_loader_bench;
    localparam int CW   = 8;
    localparam int HALF = 2;
    localparam int MHZ  = 250;
    localparam int WUS  = 1;
    localparam int TMO  = MHZ * WUS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          start_i = 1'b0;
    logic [CW-1:0] len_i = '0;
    logic [7:0]    bdata = '0;
    logic          bvalid = 1'b0;
    logic          bready, prog, cclk, din, busy, ok, tmo, crc;
    logic          init_i = 1'b0, done_i = 1'b0;

    fpga_serial_loader #(.CNT_W(CW), .HALF_CYC(HALF), .CLK_MHZ(MHZ), .WAIT_US(WUS))
        u_fpga_serial_loader (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
        .byte_data_i(bdata), .byte_valid_i(bvalid), .byte_ready_o(bready),
        .prog_o(prog), .cclk_o(cclk), .din_o(din), .init_i(init_i), .done_i(done_i),
        .busy_o(busy), .ok_o(ok), .tmo_o(tmo), .crc_o(crc));

    int n_chk = 0, n_bad = 0;

    task automatic check(input bit cond, input string req, input int act, input int exp);
        n_chk++;
        if (!cond) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // device model and stream source settings
    bit dev_resp = 1, dev_clr = 1, prog_seen = 0, pre_phase = 0;
    int dev_done_after = -1, dev_crc_bytes = -1;
    bit gap_mode = 0, gap_tog = 0, pend = 0;
    logic [7:0] src_q[$];
    bit exp_bits[$];
    int rises_data = 0, flush_rises = 0, accepted = 0, prog_cycles = 0, busy_cycles = 0;
    int hi_run = 0, lo_run = 0;
    bit prev_cclk = 0, prev_din = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (pend) begin
                logic [7:0] v;
                v = src_q.pop_front();
                accepted++;
                for (int b = 7; b >= 0; b--) exp_bits.push_back(v[b]);
            end
            if (cclk && !prev_cclk) begin
                if (pre_phase || prog) check(1'b0, "R3 clock edge before init cleared", 1, 0);
                if (exp_bits.size() > 0) begin
                    bit eb;
                    eb = exp_bits.pop_front();
                    if (rises_data % 8 != 0) check(lo_run == HALF, "R6 low half in byte", lo_run, HALF);
                    rises_data++;
                    check(din == eb, "R5 serial bit", din, eb);
                end else begin
                    if (flush_rises > 0) check(lo_run == HALF, "R6 low half in flush", lo_run, HALF);
                    flush_rises++;
                    check(din == 1'b1, "R8 din high after data", din, 1);
                end
                hi_run = 0;
            end
            if (!cclk && prev_cclk) begin
                check(hi_run == HALF, "R6 high half", hi_run, HALF);
                lo_run = 0;
            end
            if (cclk) begin
                if (prev_cclk) check(din == prev_din, "R6 din stable while clock high", din, prev_din);
                hi_run++;
            end else begin
                lo_run++;
            end
            if (prog) prog_cycles++;
            if (busy) busy_cycles++;
            // device
            if (prog) done_i = 1'b0;
            if (prog && dev_resp) begin
                init_i = 1'b1;
                prog_seen = 1'b1;
            end
            if (!prog && prog_seen && dev_clr) begin
                init_i = 1'b0;
                prog_seen = 1'b0;
                pre_phase = 1'b0;
            end
            if (dev_crc_bytes > 0 && rises_data == 8 * dev_crc_bytes) init_i = 1'b1;
            if (dev_done_after >= 0 && flush_rises >= dev_done_after) done_i = 1'b1;
            // stream source
            gap_tog = ~gap_tog;
            bvalid = (src_q.size() > 0) && !(gap_mode && gap_tog);
            bdata  = (src_q.size() > 0) ? src_q[0] : 8'h00;
            pend   = bvalid && bready;
            prev_cclk = cclk;
            prev_din  = din;
        end
    end

    task automatic run(input int len, input bit gap, input int done_after, input int crc_bytes,
                       input bit resp, input bit clr, input int poke);
        @(posedge clk); #1;
        src_q.delete();
        exp_bits.delete();
        for (int i = 0; i < len; i++) src_q.push_back(8'hA5 + 8'(i * 8'h37));
        rises_data = 0; flush_rises = 0; accepted = 0; prog_cycles = 0; busy_cycles = 0;
        dev_resp = resp; dev_clr = clr; dev_done_after = done_after; dev_crc_bytes = crc_bytes;
        gap_mode = gap; init_i = 1'b0; done_i = 1'b0; prog_seen = 1'b0; pre_phase = 1'b1;
        len_i = CW'(len);
        start_i = 1'b1;
        @(posedge clk); #1;
        start_i = 1'b0;
        check(busy && prog, "R2 request after start", {busy, prog}, 3);
        check(!ok && !tmo && !crc, "R11 flags cleared at start", {ok, tmo, crc}, 0);
        for (int c = 0; c < 20000; c++) begin
            @(posedge clk); #1;
            if (c == poke) begin
                len_i = 8'd1;
                start_i = 1'b1;
                @(posedge clk); #1;
                start_i = 1'b0;
            end
            if (!busy) break;
        end
        check(!busy, "R4 load ends", busy, 0);
    endtask

    initial begin
        #(190000 * 4);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !prog && !cclk && !bready, "R1 idle after reset", {busy, prog, cclk, bready}, 0);
        check(!ok && !tmo && !crc, "R1 flags after reset", {ok, tmo, crc}, 0);

        // normal load
        run(3, 0, 3, -1, 1, 1, -1);
        check(ok, "R8 success", ok, 1);
        check(accepted == 3, "R5 bytes taken", accepted, 3);
        check(rises_data == 24, "R5 data edges", rises_data, 24);
        check(flush_rises >= 3, "R8 clocking until done", flush_rises, 3);
        check(prog_cycles == 3, "R2 request length", prog_cycles, 3);

        repeat (25) @(posedge clk);
        #1 check(ok && !tmo && !crc, "R11 flags held while idle", {ok, tmo, crc}, 4);

        // stalled stream with ignored start mid-load
        run(4, 1, 2, -1, 1, 1, 40);
        check(ok, "R10 result kept", ok, 1);
        check(accepted == 4, "R10 byte count kept", accepted, 4);
        check(rises_data == 32, "R5 data edges with stalls", rises_data, 32);

        // init never rises
        run(2, 0, 1, -1, 0, 1, -1);
        check(tmo && !ok && !crc, "R4 timeout on request", {ok, tmo, crc}, 2);
        check(busy_cycles == TMO, "R4 request wait length", busy_cycles, TMO);
        check(rises_data + flush_rises == 0, "R3 no clock on timeout", rises_data + flush_rises, 0);

        // init never clears
        run(2, 0, 1, -1, 1, 0, -1);
        check(tmo, "R4 timeout on init clear", tmo, 1);
        check(busy_cycles == 3 + TMO, "R4 clear wait length", busy_cycles, 3 + TMO);
        check(prog_cycles == 3, "R2 request released", prog_cycles, 3);

        // checksum error after first byte
        run(4, 0, -1, 1, 1, 1, -1);
        check(crc && !ok && !tmo, "R7 checksum error flag", {ok, tmo, crc}, 1);
        check(accepted < 4, "R7 load stopped", accepted, 1);
        check(rises_data == 8 * accepted, "R7 no partial byte", rises_data, 8 * accepted);

        // done never rises
        run(1, 0, -1, -1, 1, 1, -1);
        check(tmo && !ok, "R9 timeout after data", {ok, tmo}, 1);
        check(flush_rises > 0, "R9 clocking after data", flush_rises, 1);
        check(accepted == 1, "R9 data sent", accepted, 1);

        // zero-length load
        run(0, 0, 2, -1, 1, 1, -1);
        check(ok, "R12 zero length success", ok, 1);
        check(rises_data == 0 && accepted == 0, "R12 no data bits", rises_data, 0);
        check(flush_rises >= 2, "R12 post-load clocking", flush_rises, 2);

        repeat (5) @(posedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule